// File: doc/BRIEF.md
# Multi-Channel Conversion Result Readout Pointer

This block is the digital output side of a sequential sampling converter that digitises up to four channels per sequence. A start request opens a sequence and latches how many channels take part; each end-of-conversion strobe then delivers one 12-bit result. The result goes into the next free output register. A busy indication stays high until every active channel has delivered its result.

The host reads results over a parallel bus using an active-low chip-select and an active-low read strobe. A read pointer selects which output register drives the bus, and a first-data flag is high whenever that pointer sits at the first register.

The host can read in two ways. It can read each result between conversions. In that case a read does not move the pointer, and the pointer moves when the next conversion completes. It can also read everything after the sequence has finished. In that case the pointer moves on the rising edge of each read strobe. The read of the last active channel returns the pointer to the first register.

Top module: `conv_readout_ptr`

## Requirements
- R1: After reset the pointer is at register 0, `first_o` is 1, and both `busy_o` and `data_oe_o` are 0.
- R2: A one-cycle `start_i` sets `busy_o` at the next clock edge and latches the channel count as `nch_m1_i + 1` (`nch_m1_i` = 0 means one channel, 3 means four). `busy_o` falls at the clock edge that stores the last result of that count.
- R3: An `eoc_i` pulse while busy stores `result_i` in register k, where k is the number of results already stored in the sequence, so the first result overwrites register 0. An `eoc_i` while not busy stores nothing.
- R4: A read of a valid result whose successor has not been converted yet leaves the pointer in place, and repeated reads return the same data. When the conversion that fills the next register completes, the pointer moves to it.
- R5: A read of a valid result whose successor is already stored moves the pointer forward on the read strobe's rising edge. Reading after a finished sequence therefore drops `first_o` after the first read.
- R6: A read of the last active channel, once that result is stored, returns the pointer to register 0 and raises `first_o`.
- R7: A read while the register at the pointer holds no result of the current sequence leaves the pointer unchanged and returns that register's current contents.
- R8: `data_oe_o` is 1 in the cycle after a cycle in which `cs_n_i` and `rd_n_i` are both 0, and 0 otherwise.
- R9: `first_o` is 1 exactly when the pointer is at register 0.
- R10: `start_i` leaves the pointer where it is, unless the pointer lies at or beyond the new channel count; in that case the pointer returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request opening a conversion sequence |
| nch_m1_i | input | 2 | Active channel count minus one, sampled with `start_i` |
| eoc_i | input | 1 | One-cycle end-of-conversion strobe |
| result_i | input | 12 | Conversion result that accompanies `eoc_i` |
| cs_n_i | input | 1 | Chip-select, active low |
| rd_n_i | input | 1 | Read strobe, active low; a read completes on its rising edge |
| data_o | output | 12 | Contents of the register selected by the pointer (registered) |
| data_oe_o | output | 1 | Bus drive enable for `data_o` |
| first_o | output | 1 | High while the pointer selects register 0 |
| busy_o | output | 1 | High while the conversion sequence is in progress |

## Verification
The assertions check the following on every cycle:
- the pointer stays inside the active channel count;
- the pointer holds while a deferred read waits for its conversion;
- the pointer wraps to register 0 after the last channel is read;
- a read without a stored result has no effect on the pointer;
- the busy and stored-count rules at start and at the last result;
- the bus-enable timing.

Only the bench scenarios can show which data actually reaches the bus. These scenarios cover reads between conversions, reads after the sequence, a two-channel sequence, an ignored stray strobe, and a restart with the pointer left mid-way or out of range. They compare `data_o` and `first_o` with results written earlier.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;
  // Outcome of one completed host read
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,  // nothing stored at pointer
    RD_ADV   = 2'd1,  // successor stored: step now
    RD_WRAP  = 2'd2,  // last active channel: back to 0
    RD_DEFER = 2'd3   // successor not converted yet: wait
  } rd_act_e;
endpackage

// File: rtl/rd_seq_ctl.sv
module rd_seq_ctl #(
  parameter int MAX_CH = 4,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PTR_W-1:0] nch_m1_i,
  input  logic             eoc_i,
  output logic             busy_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] wr_cnt_o,
  output logic [CNT_W-1:0] nch_o,
  output logic [CNT_W-1:0] start_nch_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CH);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, nch_q, req_nch;

  always_comb begin
    req_nch = CNT_W'(nch_m1_i) + CNT_W'(1);
    if (req_nch > MAX_C) req_nch = MAX_C;
  end

  assign wr_en_o     = eoc_i & busy_q & ~start_i;
  assign wr_idx_o    = cnt_q[PTR_W-1:0];
  assign wr_cnt_o    = cnt_q;
  assign nch_o       = nch_q;
  assign busy_o      = busy_q;
  assign start_nch_o = req_nch;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      nch_q  <= MAX_C;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      nch_q  <= req_nch;
    end else if (wr_en_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q + CNT_W'(1) == nch_q) busy_q <= 1'b0;
    end
  end

  // R2: start opens a fresh sequence
  p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o && wr_cnt_o == '0));
  // R2: busy ends with the last result
  p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_cnt_o + CNT_W'(1) == nch_o) |=> !busy_o);
  // R3: strobes outside a sequence store nothing
  p_idle_eoc_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(wr_cnt_o));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    wr_cnt_o <= nch_o);
endmodule

// File: rtl/rd_result_store.sv
module rd_result_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Single write port, registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
    rd_data_o <= mem[rd_idx_i];
  end
endmodule

// File: rtl/rd_pointer_ctl.sv
module rd_pointer_ctl
  import conv_rd_pkg::*;
#(
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_nch_i,
  input  logic             rd_done_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] nch_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             first_o
);
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             pend_q, pend_n, first_q;
  logic [CNT_W-1:0] ptr_x, succ_x;
  rd_act_e          act;

  assign ptr_x  = CNT_W'(ptr_q);
  assign succ_x = ptr_x + CNT_W'(1);

  always_comb begin
    if (ptr_x >= wr_cnt_i)      act = RD_NONE;
    else if (succ_x == nch_i)   act = RD_WRAP;
    else if (succ_x < wr_cnt_i) act = RD_ADV;
    else                        act = RD_DEFER;
  end

  always_comb begin
    ptr_n  = ptr_q;
    pend_n = pend_q;
    if (start_i) begin
      pend_n = 1'b0;
      if (ptr_x >= start_nch_i) ptr_n = '0;
    end else begin
      if (rd_done_i && !pend_q) begin
        unique case (act)
          RD_ADV:   ptr_n = ptr_q + PTR_W'(1);
          RD_WRAP:  ptr_n = '0;
          RD_DEFER: pend_n = 1'b1;
          default:  ;
        endcase
      end
      // A deferred read completes when its successor is written
      if (wr_en_i && pend_n && CNT_W'(wr_idx_i) == succ_x) begin
        ptr_n  = ptr_q + PTR_W'(1);
        pend_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      pend_q  <= 1'b0;
      first_q <= 1'b1;
    end else begin
      ptr_q   <= ptr_n;
      pend_q  <= pend_n;
      first_q <= (ptr_n == '0);
    end
  end

  assign ptr_o   = ptr_q;
  assign first_o = first_q;

  // R4: pointer holds while a deferred read waits for its conversion
  p_hold_deferred_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !wr_en_i && !start_i) |=> $stable(ptr_o));
  // R6: last channel read wraps to register 0
  p_wrap_last_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_done_i && !pend_q && !start_i && succ_x == nch_i && ptr_x < wr_cnt_i)
      |=> (ptr_o == '0 && first_o));
  // R7: read without a stored result does not move the pointer
  p_no_result_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_done_i && !start_i && !wr_en_i && ptr_x >= wr_cnt_i) |=> $stable(ptr_o));
  // R10: pointer stays within the active channel count
  p_in_range_r10: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(ptr_o) < nch_i);
endmodule

// File: rtl/conv_readout_ptr.sv
module conv_readout_ptr #(
  parameter int DATA_W = 12,
  parameter int MAX_CH = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [$clog2(MAX_CH)-1:0]   nch_m1_i,
  input  logic                        eoc_i,
  input  logic [DATA_W-1:0]           result_i,
  input  logic                        cs_n_i,
  input  logic                        rd_n_i,
  output logic [DATA_W-1:0]           data_o,
  output logic                        data_oe_o,
  output logic                        first_o,
  output logic                        busy_o
);
  localparam int PTR_W = $clog2(MAX_CH);
  localparam int CNT_W = $clog2(MAX_CH + 1);

  logic             rd_n_q, cs_n_q, oe_q, rd_done;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx, ptr;
  logic [CNT_W-1:0] wr_cnt, nch, start_nch;

  // Read completes on the strobe's rising edge with chip-select held low
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n_q <= 1'b1;
      cs_n_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      rd_n_q <= rd_n_i;
      cs_n_q <= cs_n_i;
      oe_q   <= ~cs_n_i & ~rd_n_i;
    end
  end
  assign rd_done   = ~rd_n_q & rd_n_i & ~cs_n_q;
  assign data_oe_o = oe_q;

  rd_seq_ctl #(.MAX_CH(MAX_CH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .nch_m1_i(nch_m1_i),
    .eoc_i(eoc_i), .busy_o(busy_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_cnt_o(wr_cnt), .nch_o(nch), .start_nch_o(start_nch)
  );

  rd_result_store #(.DATA_W(DATA_W), .DEPTH(MAX_CH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(result_i),
    .rd_idx_i(ptr), .rd_data_o(data_o)
  );

  rd_pointer_ctl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst(rst), .start_i(start_i), .start_nch_i(start_nch),
    .rd_done_i(rd_done), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_cnt_i(wr_cnt), .nch_i(nch), .ptr_o(ptr), .first_o(first_o)
  );

  // R8: bus enable follows the strobes one cycle later
  p_oe_on_r8: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_i && !rd_n_i) |=> data_oe_o);
  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i || rd_n_i) |=> !data_oe_o);
endmodule

// File: tb/tb_conv_readout_ptr.sv
module tb_conv_readout_ptr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  nch_m1_i = 2'd3;
  logic        eoc_i = 1'b0;
  logic [11:0] result_i = '0;
  logic        cs_n_i = 1'b1;
  logic        rd_n_i = 1'b1;
  logic [11:0] data_o;
  logic        data_oe_o, first_o, busy_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  conv_readout_ptr dut (
    .clk(clk), .rst(rst), .start_i(start_i), .nch_m1_i(nch_m1_i),
    .eoc_i(eoc_i), .result_i(result_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .first_o(first_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input logic [1:0] m1);
    @(negedge clk); start_i = 1'b1; nch_m1_i = m1;
    @(negedge clk); start_i = 1'b0;
    idle(2);
  endtask

  task automatic do_eoc(input logic [11:0] v);
    @(negedge clk); eoc_i = 1'b1; result_i = v;
    @(negedge clk); eoc_i = 1'b0;
    idle(2);
  endtask

  // Full read cycle; returns bus data and enable seen mid-strobe
  task automatic do_read(output logic [11:0] d, output logic oe);
    @(negedge clk); cs_n_i = 1'b0; rd_n_i = 1'b0;
    idle(2);
    d = data_o; oe = data_oe_o;
    rd_n_i = 1'b1;
    @(negedge clk); cs_n_i = 1'b1;
    idle(2);
  endtask

  task automatic t_reset;
    check("R1 first", int'(first_o), 1);
    check("R1 busy", int'(busy_o), 0);
    check("R1 oe", int'(data_oe_o), 0);
    // chip-select alone does not enable the bus
    @(negedge clk); cs_n_i = 1'b0; idle(2);
    check("R8 cs only", int'(data_oe_o), 0);
    cs_n_i = 1'b1; idle(1);
  endtask

  task automatic t_after_seq;
    logic [11:0] d; logic oe;
    do_start(2'd3);
    check("R2 busy set", int'(busy_o), 1);
    for (int i = 0; i < 4; i++) begin
      if (i == 3) check("R2 busy before last", int'(busy_o), 1);
      do_eoc(12'h1A0 + 12'(i));
    end
    check("R2 busy clear", int'(busy_o), 0);
    check("R9 first before read", int'(first_o), 1);
    for (int i = 0; i < 4; i++) begin
      do_read(d, oe);
      check("R8 oe during read", int'(oe), 1);
      check("R5 data", int'(d), 'h1A0 + i);
      if (i < 3) check("R5 first after read", int'(first_o), 0);
    end
    check("R6 wrap first", int'(first_o), 1);
    check("R8 oe idle", int'(data_oe_o), 0);
  endtask

  task automatic t_during_seq;
    logic [11:0] d; logic oe;
    do_start(2'd3);
    for (int i = 0; i < 4; i++) begin
      do_eoc(12'h2B0 + 12'(i));
      check("R4 first follows eoc", int'(first_o), (i == 0) ? 1 : 0);
      do_read(d, oe);
      check("R4 data", int'(d), 'h2B0 + i);
      if (i == 0) begin
        do_read(d, oe);
        check("R4 repeat same data", int'(d), 'h2B0);
        check("R4 pointer held", int'(first_o), 1);
      end
    end
    check("R6 wrap after deferred", int'(first_o), 1);
    check("R2 busy done", int'(busy_o), 0);
  endtask

  task automatic t_two_ch;
    logic [11:0] d; logic oe;
    do_start(2'd1);
    do_read(d, oe);
    check("R7 empty read data", int'(d), 'h2B0);
    check("R7 empty read first", int'(first_o), 1);
    do_eoc(12'h3C0);
    do_eoc(12'h3C1);
    check("R2 two ch busy clear", int'(busy_o), 0);
    do_read(d, oe);
    check("R3 reg0", int'(d), 'h3C0);
    do_read(d, oe);
    check("R3 reg1", int'(d), 'h3C1);
    check("R6 wrap at two", int'(first_o), 1);
  endtask

  task automatic t_stray_eoc;
    logic [11:0] d; logic oe;
    do_eoc(12'hABC);
    do_read(d, oe);
    check("R3 idle eoc ignored", int'(d), 'h3C0);
    check("R5 step", int'(first_o), 0);
  endtask

  task automatic t_restart;
    logic [11:0] d; logic oe;
    do_start(2'd3);
    check("R10 pointer kept", int'(first_o), 0);
    do_eoc(12'h4D0);
    do_eoc(12'h4D1);
    do_read(d, oe);
    check("R10 reads reg1", int'(d), 'h4D1);
    do_start(2'd0);
    check("R10 out of range to 0", int'(first_o), 1);
    do_eoc(12'h5E0);
    do_read(d, oe);
    check("R6 single ch", int'(d), 'h5E0);
    check("R6 single ch first", int'(first_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_after_seq();
    t_during_seq();
    t_two_ch();
    t_stray_eoc();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule